// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers packets from the differential pair of a low-speed USB link. Both lines pass through a two-flop synchronizer. The block then samples the pair with a local clock that runs at a fixed multiple of the bit rate, by default 12 clocks per bit. A phase counter restarts on every line transition, and each bit is taken close to its centre.

The receiver first waits for the bus to sit idle. It then hunts for the sync field and locks onto the transition from idle to the opposite state. Reception starts once that state has held for two bit times in a row. Each bit after that is NRZI-decoded and stuffed bits are removed. Bytes are assembled least significant bit first.

The first byte is checked as a PID and presented on its own strobe. Later bytes appear on a data strobe. An end-of-packet strobe closes every packet the receiver accepted and carries the error flags. A downstream CRC checker consumes the data strobe. The PID byte and the error flags tell it whether to keep the payload.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, and while the line idles in J (dPlus=0, dMinus=1), no strobe or error flag is asserted.
- R2: Reception begins only after the receiver has seen a J-to-K edge (K is dPlus=1, dMinus=0) followed by two consecutive K bit times. A K followed by a J sends the receiver back to hunting for the next J-to-K edge, so a sync field with extra KJ pairs before the final KK is still accepted.
- R3: No line change between two bit samples decodes as 1 and a change decodes as 0. The first received bit is bit 0 of the byte, and each completed byte is presented once on its strobe.
- R4: After six consecutive decoded 1s (the final KK of sync counts as one), the next bit is a stuff bit. A stuff bit that is a transition is dropped from the data.
- R5: A stuff bit that is not a transition ends the packet with eopValid and errStuff. No further pidValid or dataValid is issued for that packet.
- R6: An SE0 (both lines low) at a bit sample ends the packet with eopValid and all error flags low. This holds when the SE0 lands in the slot of an expected stuff bit after six 1s.
- R7: The PID is accepted only if bits 7..4 equal the bitwise inverse of bits 3..0. On a mismatch there is no pidValid and no dataValid, and eopValid comes with errPid. An SE0 before the eighth PID bit also ends the packet with errPid.
- R8: Up to MAX_DATA data bytes after the PID are delivered. The byte after that is not delivered, and the packet ends with eopValid and errOverflow.
- R9: The sample phase restarts on every observed line transition. A bit period of 11 or 13 clocks against the nominal 12 is therefore received correctly, as long as no run without a transition is longer than five bits.
- R10: If sync is not completed within SYNC_LIMIT bit times of the first K, the receiver stops hunting and asserts no strobe. It then needs the line to rest in J for ARM_BITS bit times before it hunts again, and after that it receives the next packet normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVERSAMPLE cycles per bit |
| rstN | input | 1 | Asynchronous active-low reset |
| dPlus | input | 1 | D+ line, asynchronous |
| dMinus | input | 1 | D- line, asynchronous |
| pidValid | output | 1 | One-cycle strobe, pidByte holds a checked PID |
| pidByte | output | 8 | Received PID byte |
| dataValid | output | 1 | One-cycle strobe, dataByte holds the next data byte |
| dataByte | output | 8 | Received data byte |
| eopValid | output | 1 | One-cycle strobe closing the packet |
| errStuff | output | 1 | With eopValid: stuff bit was not a transition |
| errOverflow | output | 1 | With eopValid: more than MAX_DATA data bytes |
| errPid | output | 1 | With eopValid: PID check failed or PID incomplete |

## Verification
The receive path is exercised with several kinds of traffic:
- Plain packets whose bytes alternate ones and zeros check the NRZI decode and the bit order.
- Bytes of all ones and bytes ending in six ones separate correct unstuffing from a stuff bit that is kept or wrongly flagged.
- An SE0 placed in a stuff slot shows whether end detection takes precedence.
- A forced stuff bit without a transition, a PID with a broken complement, a truncated PID and an over-long payload each have to raise exactly their own flag.
- A lengthened sync field, bit periods of 11 and 13 clocks, and a sync that never completes show the edge-alignment and timeout logic apart from the decoder.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  localparam int unsigned BYTE_W    = 8;
  // Run of decoded ones after which a stuff bit follows.
  localparam int unsigned STUFF_RUN = 6;

  // Encoded as {dPlus, dMinus}.
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } lineState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic startRx;  // sync done: seed the decoder for PID bit 0
    logic rxEn;     // decode bits at each sample tick
  } rxCmd_t;

  // Status from datapath to control.
  typedef struct packed {
    logic              tick;      // bit centre sample point
    logic              edgeJK;    // J-to-K transition this cycle
    lineState_t        lineNow;   // synchronized line state
    logic              byteDone;  // eighth data bit decoded at this tick
    logic [BYTE_W-1:0] byteVal;   // completed byte, valid with byteDone
    logic              stuffBad;  // stuff slot carried no transition
  } rxStat_t;

endpackage

// File: rtl/usb_ls_rx_dp.sv
module usb_ls_rx_dp
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 12
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    dPlus,
  input  logic    dMinus,
  input  rxCmd_t  cmd,
  output rxStat_t stat
);

  localparam int unsigned PW = $clog2(OVERSAMPLE);
  localparam int unsigned RW = $clog2(STUFF_RUN + 1);
  localparam int unsigned CW = $clog2(BYTE_W);
  localparam logic [PW-1:0] HALF     = PW'(OVERSAMPLE / 2);
  localparam logic [PW-1:0] LAST     = PW'(OVERSAMPLE - 1);
  localparam logic [RW-1:0] RUN_STOP = RW'(STUFF_RUN);
  localparam logic [CW-1:0] BIT_LAST = CW'(BYTE_W - 1);

  // Two-flop synchronizer plus one history stage for edge detection.
  logic [1:0] syncA, syncB, linePrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= LN_J;
      syncB    <= LN_J;
      linePrev <= LN_J;
    end else begin
      syncA    <= {dPlus, dMinus};
      syncB    <= syncA;
      linePrev <= syncB;
    end
  end

  lineState_t lineNow, lineOld;
  logic       lineEdge;
  assign lineNow  = lineState_t'(syncB);
  assign lineOld  = lineState_t'(linePrev);
  assign lineEdge = (syncB != linePrev);

  // Sample phase: the edge cycle counts as phase 0, the sample lands at HALF.
  logic [PW-1:0] phase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phase <= '0;
    else if (lineEdge)     phase <= PW'(1);
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  logic tick;
  assign tick = (phase == HALF) && !lineEdge;

  // NRZI decode and unstuffing.
  lineState_t        lastSample;
  logic [RW-1:0]     onesRun;
  logic [CW-1:0]     bitCnt;
  logic [BYTE_W-1:0] shiftReg;

  logic              decodeEn, bitVal, stuffSlot;
  logic [BYTE_W-1:0] shiftNext;
  assign decodeEn  = cmd.rxEn && tick && (lineNow != LN_SE0);
  assign bitVal    = (lineNow == lastSample);
  assign stuffSlot = (onesRun == RUN_STOP);
  assign shiftNext = {bitVal, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSample <= LN_J;
      onesRun    <= '0;
      bitCnt     <= '0;
      shiftReg   <= '0;
    end else if (cmd.startRx) begin
      // The closing KK of sync is one decoded 1 ending in K.
      lastSample <= LN_K;
      onesRun    <= RW'(1);
      bitCnt     <= '0;
      shiftReg   <= '0;
    end else if (decodeEn) begin
      lastSample <= lineNow;
      if (stuffSlot) begin
        onesRun <= '0;
      end else begin
        shiftReg <= shiftNext;
        bitCnt   <= bitCnt + 1'b1;
        onesRun  <= bitVal ? onesRun + 1'b1 : '0;
      end
    end
  end

  always_comb begin
    stat.tick     = tick;
    stat.edgeJK   = lineEdge && (lineOld == LN_J) && (lineNow == LN_K);
    stat.lineNow  = lineNow;
    stat.byteDone = decodeEn && !stuffSlot && (bitCnt == BIT_LAST);
    stat.byteVal  = shiftNext;
    stat.stuffBad = decodeEn && stuffSlot && bitVal;
  end

  // The run of ones never passes the stuff limit.
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    onesRun <= RUN_STOP);

  // Bit position moves only at a sample tick or at a receive start.
  p_bits_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !cmd.startRx) |=> $stable(bitCnt));

  // A stuff slot never completes a byte.
  p_stuff_no_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    stat.stuffBad |-> !stat.byteDone);

endmodule

// File: rtl/usb_ls_rx_ctl.sv
module usb_ls_rx_ctl
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned MAX_DATA   = 8,
  parameter int unsigned SYNC_LIMIT = 24,
  parameter int unsigned ARM_BITS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStat_t           stat,
  output rxCmd_t            cmd,
  output logic              pidValid,
  output logic [BYTE_W-1:0] pidByte,
  output logic              dataValid,
  output logic [BYTE_W-1:0] dataByte,
  output logic              eopValid,
  output logic              errStuff,
  output logic              errOverflow,
  output logic              errPid
);

  localparam int unsigned DW = $clog2(MAX_DATA + 1);
  localparam int unsigned TW = $clog2(SYNC_LIMIT + 1);
  localparam int unsigned AW = $clog2(ARM_BITS + 1);
  localparam logic [DW-1:0] DATA_MAX = DW'(MAX_DATA);
  localparam logic [TW-1:0] TMR_LAST = TW'(SYNC_LIMIT - 1);
  localparam logic [AW-1:0] ARM_LAST = AW'(ARM_BITS - 1);
  localparam int unsigned NIB = BYTE_W / 2;

  typedef enum logic [2:0] {
    ST_ARM,     // wait for the bus to rest in J
    ST_HUNT,    // wait for the first J-to-K edge
    ST_GOTK,    // in a K bit after an edge
    ST_AWAITK,  // one K seen, need a second
    ST_RESEEK,  // sync interrupted, wait for the next J-to-K edge
    ST_RECV,    // decoding the packet
    ST_DRAIN    // packet aborted, wait for SE0
  } rxState_t;

  rxState_t      state;
  logic [AW-1:0] armCnt;
  logic [TW-1:0] syncTmr;
  logic [DW-1:0] dataCnt;
  logic          pidSeen;
  logic          pidOk;

  assign pidOk = (stat.byteVal[BYTE_W-1:NIB] == ~stat.byteVal[NIB-1:0]);

  always_comb begin
    cmd.startRx = (state == ST_AWAITK) && stat.tick && (stat.lineNow == LN_K);
    cmd.rxEn    = (state == ST_RECV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_ARM;
      armCnt      <= '0;
      syncTmr     <= '0;
      dataCnt     <= '0;
      pidSeen     <= 1'b0;
      pidValid    <= 1'b0;
      pidByte     <= '0;
      dataValid   <= 1'b0;
      dataByte    <= '0;
      eopValid    <= 1'b0;
      errStuff    <= 1'b0;
      errOverflow <= 1'b0;
      errPid      <= 1'b0;
    end else begin
      pidValid    <= 1'b0;
      dataValid   <= 1'b0;
      eopValid    <= 1'b0;
      errStuff    <= 1'b0;
      errOverflow <= 1'b0;
      errPid      <= 1'b0;
      unique case (state)
        ST_ARM: begin
          if (stat.tick) begin
            if (stat.lineNow != LN_J)   armCnt <= '0;
            else if (armCnt == ARM_LAST) state <= ST_HUNT;
            else                        armCnt <= armCnt + 1'b1;
          end
        end
        ST_HUNT: begin
          if (stat.edgeJK) begin
            state   <= ST_GOTK;
            syncTmr <= '0;
          end
        end
        ST_GOTK, ST_AWAITK, ST_RESEEK: begin
          if (state == ST_RESEEK && stat.edgeJK) state <= ST_GOTK;
          if (stat.tick) begin
            syncTmr <= syncTmr + 1'b1;
            if (stat.lineNow == LN_SE0) begin
              state  <= ST_ARM;
              armCnt <= '0;
            end else if (state == ST_GOTK) begin
              state <= (stat.lineNow == LN_K) ? ST_AWAITK : ST_RESEEK;
            end else if (state == ST_AWAITK) begin
              if (stat.lineNow == LN_K) begin
                state   <= ST_RECV;
                pidSeen <= 1'b0;
                dataCnt <= '0;
              end else begin
                state <= ST_RESEEK;
              end
            end
            // Timeout, unless this very tick completes sync.
            if (syncTmr == TMR_LAST && !cmd.startRx) begin
              state  <= ST_ARM;
              armCnt <= '0;
            end
          end
        end
        ST_RECV: begin
          if (stat.tick && stat.lineNow == LN_SE0) begin
            eopValid <= 1'b1;
            errPid   <= !pidSeen;
            state    <= ST_ARM;
            armCnt   <= '0;
          end else if (stat.stuffBad) begin
            eopValid <= 1'b1;
            errStuff <= 1'b1;
            state    <= ST_DRAIN;
          end else if (stat.byteDone) begin
            if (!pidSeen) begin
              if (pidOk) begin
                pidValid <= 1'b1;
                pidByte  <= stat.byteVal;
                pidSeen  <= 1'b1;
              end else begin
                eopValid <= 1'b1;
                errPid   <= 1'b1;
                state    <= ST_DRAIN;
              end
            end else if (dataCnt == DATA_MAX) begin
              eopValid    <= 1'b1;
              errOverflow <= 1'b1;
              state       <= ST_DRAIN;
            end else begin
              dataValid <= 1'b1;
              dataByte  <= stat.byteVal;
              dataCnt   <= dataCnt + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (stat.tick && stat.lineNow == LN_SE0) begin
            state  <= ST_ARM;
            armCnt <= '0;
          end
        end
        default: state <= ST_ARM;
      endcase
    end
  end

  // At most one output strobe per cycle.
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pidValid, dataValid, eopValid}));

  // Error flags appear only together with the end strobe.
  p_err_with_eop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errStuff || errOverflow || errPid) |-> eopValid);

  // Data count never exceeds the buffer limit.
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataCnt <= DATA_MAX);

  // A presented PID always carries its complement.
  p_pid_form_r7: assert property (@(posedge clk) disable iff (!rstN)
    pidValid |-> (pidByte[BYTE_W-1:NIB] == ~pidByte[NIB-1:0]));

  // Data is only delivered after a PID of the same packet.
  p_data_after_pid_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> pidSeen);

  // Error strobes always come from an active receive.
  p_eop_from_recv_r6: assert property (@(posedge clk) disable iff (!rstN)
    eopValid |-> ($past(state) == ST_RECV));

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 12,
  parameter int unsigned MAX_DATA   = 8,
  parameter int unsigned SYNC_LIMIT = 24,
  parameter int unsigned ARM_BITS   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dPlus,
  input  logic       dMinus,
  output logic       pidValid,
  output logic [7:0] pidByte,
  output logic       dataValid,
  output logic [7:0] dataByte,
  output logic       eopValid,
  output logic       errStuff,
  output logic       errOverflow,
  output logic       errPid
);

  rxCmd_t  rxCmd;
  rxStat_t rxStat;

  usb_ls_rx_dp #(
    .OVERSAMPLE(OVERSAMPLE)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .dPlus (dPlus),
    .dMinus(dMinus),
    .cmd   (rxCmd),
    .stat  (rxStat)
  );

  usb_ls_rx_ctl #(
    .MAX_DATA  (MAX_DATA),
    .SYNC_LIMIT(SYNC_LIMIT),
    .ARM_BITS  (ARM_BITS)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (rxStat),
    .cmd        (rxCmd),
    .pidValid   (pidValid),
    .pidByte    (pidByte),
    .dataValid  (dataValid),
    .dataByte   (dataByte),
    .eopValid   (eopValid),
    .errStuff   (errStuff),
    .errOverflow(errOverflow),
    .errPid     (errPid)
  );

endmodule

// File: tb/usb_ls_rx_bench.sv
module usb_ls_rx_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       dPlus, dMinus;
  logic       pidValid, dataValid, eopValid;
  logic       errStuff, errOverflow, errPid;
  logic [7:0] pidByte, dataByte;

  always #10 clk = ~clk;  // 50 MHz

  usb_ls_rx u_usb_ls_rx (
    .clk(clk), .rstN(rstN), .dPlus(dPlus), .dMinus(dMinus),
    .pidValid(pidValid), .pidByte(pidByte),
    .dataValid(dataValid), .dataByte(dataByte),
    .eopValid(eopValid), .errStuff(errStuff),
    .errOverflow(errOverflow), .errPid(errPid)
  );

  int nChecks = 0;
  int nFail   = 0;

  // Output log, sampled on the falling edge.
  int         pidCnt, dataCnt, eopCnt;
  logic [7:0] pidLast;
  logic [7:0] dataLog [16];
  logic       lastStuff, lastOvf, lastPidErr;

  always @(negedge clk) begin
    if (pidValid) begin pidCnt++; pidLast = pidByte; end
    if (dataValid) begin
      if (dataCnt < 16) dataLog[dataCnt] = dataByte;
      dataCnt++;
    end
    if (eopValid) begin
      eopCnt++;
      lastStuff = errStuff; lastOvf = errOverflow; lastPidErr = errPid;
    end
  end

  // Line encoder state.
  int         bitClks = 12;
  logic       curK;
  int         onesRun;
  logic       badStuff;
  logic [7:0] sentD [16];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    pidCnt = 0; dataCnt = 0; eopCnt = 0; pidLast = '0;
    lastStuff = 0; lastOvf = 0; lastPidErr = 0;
  endtask

  task automatic drive(input logic dp, input logic dm, input int nbits);
    dPlus = dp; dMinus = dm;
    repeat (nbits * bitClks) @(negedge clk);
  endtask

  task automatic putLine();
    if (curK) drive(1'b1, 1'b0, 1); else drive(1'b0, 1'b1, 1);
  endtask

  task automatic idle(input int nbits);
    curK = 1'b0;
    drive(1'b0, 1'b1, nbits);
  endtask

  task automatic sendSync(input int pairs);
    for (int i = 0; i < pairs; i++) begin
      curK = 1'b1; putLine(); curK = 1'b0; putLine();
    end
    curK = 1'b1; putLine(); putLine();
    onesRun = 1;
  endtask

  task automatic sendBitN(input logic b);
    if (onesRun == 6) begin
      if (!badStuff) curK = ~curK;
      badStuff = 1'b0;
      putLine();
      onesRun = 0;
    end
    if (!b) curK = ~curK;
    putLine();
    onesRun = b ? onesRun + 1 : 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBitN(v[i]);
  endtask

  task automatic sendEop();
    drive(1'b0, 1'b0, 2);
    idle(4);
  endtask

  task automatic sendPacket(input int pairs, input logic [7:0] pid, input int n);
    clearLog();
    sendSync(pairs);
    sendByte(pid);
    for (int i = 0; i < n; i++) sendByte(sentD[i]);
    sendEop();
  endtask

  task automatic expectPacket(input string req, input int pidN, input logic [7:0] pid,
                              input int nData, input int eopN,
                              input logic eS, input logic eO, input logic eP);
    check(pidCnt == pidN, req, "pid strobes", pidCnt, pidN);
    if (pidN > 0) check(pidLast == pid, req, "pid value", pidLast, pid);
    check(dataCnt == nData, req, "data strobes", dataCnt, nData);
    for (int i = 0; i < nData && i < dataCnt && i < 16; i++)
      check(dataLog[i] == sentD[i], req, $sformatf("data byte %0d", i), dataLog[i], sentD[i]);
    check(eopCnt == eopN, req, "eop strobes", eopCnt, eopN);
    if (eopN > 0) begin
      check(lastStuff == eS, req, "errStuff", lastStuff, eS);
      check(lastOvf == eO, req, "errOverflow", lastOvf, eO);
      check(lastPidErr == eP, req, "errPid", lastPidErr, eP);
    end
  endtask

  // R1: quiet after reset while idle.
  task automatic tReset();
    clearLog();
    idle(6);
    check(!pidValid && !dataValid && !eopValid, "R1", "strobes idle", 0, 0);
    check(!errStuff && !errOverflow && !errPid, "R1", "flags idle", 0, 0);
    check(pidCnt + dataCnt + eopCnt == 0, "R1", "events while idle", pidCnt + dataCnt + eopCnt, 0);
  endtask

  // R3, R6: plain packet, clean end.
  task automatic tBasic();
    sentD[0] = 8'h12; sentD[1] = 8'h34; sentD[2] = 8'hA5;
    sendPacket(3, 8'hC3, 3);
    expectPacket("R3", 1, 8'hC3, 3, 1, 0, 0, 0);
  endtask

  // R2: longer sync with extra KJ pairs.
  task automatic tLongSync();
    sentD[0] = 8'h5A;
    sendPacket(5, 8'h69, 1);
    expectPacket("R2", 1, 8'h69, 1, 1, 0, 0, 0);
  endtask

  // R4: runs of ones with transition stuff bits.
  task automatic tStuff();
    sentD[0] = 8'hFF; sentD[1] = 8'h7E; sentD[2] = 8'hFF; sentD[3] = 8'h01;
    sendPacket(3, 8'h4B, 4);
    expectPacket("R4", 1, 8'h4B, 4, 1, 0, 0, 0);
  endtask

  // R6: SE0 in the slot of an expected stuff bit.
  task automatic tSe0AtStuff();
    sentD[0] = 8'h11; sentD[1] = 8'hFC;
    sendPacket(3, 8'hC3, 2);
    expectPacket("R6", 1, 8'hC3, 2, 1, 0, 0, 0);
  endtask

  // R5: stuff bit with no transition.
  task automatic tStuffErr();
    clearLog();
    sendSync(3);
    sendByte(8'hC3);
    badStuff = 1'b1;
    sendByte(8'hFF);
    sendByte(8'h22);
    sendEop();
    expectPacket("R5", 1, 8'hC3, 0, 1, 1, 0, 0);
  endtask

  // R7: broken PID complement, and a truncated PID.
  task automatic tPidBad();
    sentD[0] = 8'h12;
    sendPacket(3, 8'hC4, 1);
    expectPacket("R7", 0, 8'h00, 0, 1, 0, 0, 1);
    clearLog();
    sendSync(3);
    for (int i = 0; i < 4; i++) sendBitN(1'(8'hC3 >> i));
    sendEop();
    expectPacket("R7", 0, 8'h00, 0, 1, 0, 0, 1);
  endtask

  // R8: exact limit, then one byte beyond it.
  task automatic tOverflow();
    for (int i = 0; i < 9; i++) sentD[i] = 8'(i * 37 + 5);
    sendPacket(3, 8'hD2, 8);
    expectPacket("R8", 1, 8'hD2, 8, 1, 0, 0, 0);
    sendPacket(3, 8'hD2, 9);
    expectPacket("R8", 1, 8'hD2, 8, 1, 0, 1, 0);
  endtask

  // R9: slow and fast senders.
  task automatic tDrift();
    sentD[0] = 8'h12; sentD[1] = 8'h34;
    bitClks = 13;
    sendPacket(3, 8'hC3, 2);
    expectPacket("R9", 1, 8'hC3, 2, 1, 0, 0, 0);
    bitClks = 11;
    sendPacket(3, 8'hE1, 2);
    expectPacket("R9", 1, 8'hE1, 2, 1, 0, 0, 0);
    bitClks = 12;
    idle(2);
  endtask

  // R10: sync that never completes, then recovery.
  task automatic tTimeout();
    clearLog();
    for (int i = 0; i < 15; i++) begin
      curK = 1'b1; putLine(); curK = 1'b0; putLine();
    end
    curK = 1'b1; putLine(); putLine();
    onesRun = 1;
    sendByte(8'hC3);
    sendEop();
    check(pidCnt + dataCnt + eopCnt == 0, "R10", "events after timeout",
          pidCnt + dataCnt + eopCnt, 0);
    sentD[0] = 8'h3C;
    sendPacket(3, 8'hC3, 1);
    expectPacket("R10", 1, 8'hC3, 1, 1, 0, 0, 0);
  endtask

  initial begin
    dPlus = 1'b0; dMinus = 1'b1; rstN = 1'b0;
    curK = 1'b0; onesRun = 0; badStuff = 1'b0;
    clearLog();
    repeat (20) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tLongSync();
    tStuff();
    tSe0AtStuff();
    tStuffErr();
    tPidBad();
    tOverflow();
    tDrift();
    tTimeout();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule